// File: doc/BRIEF.md
# Receive Flow Control Unit

This unit watches how full the receive FIFO is and throttles the far-end sender. It works in two ways. In hardware mode it drives an active-low ready-to-send line. In software mode it asks the transmit path to insert a stop character or a resume character. Both limits come from one 8-bit control byte. The stop (halt) limit is in the low nibble and the resume limit is in the high nibble. Each 4-bit field is multiplied by four so that it spans the 0 to 64 entry range of the FIFO.

The ready-to-send pin has a fixed order of precedence:
1. The RS-485 direction override. While it is set, the pin follows the transmitter's busy state.
2. Automatic flow control, driven by the FIFO level.
3. The manual control bit.

In software mode the unit sends one stop character for each upward crossing of the halt limit. It sends one resume character when the level drops back to the resume limit. A request is held, with its character, until the transmitter accepts it.

Top module: `rx_flow_ctrl`

## Requirements
- R1: After reset, rts_no is 1 and send_req_o is 0.
- R2: With rs485_en_i=0 and auto_rts_en_i=1, rts_no is 0 one cycle after rx_level_i < 4*thresh_i[3:0]. It is 1 one cycle after rx_level_i >= 4*thresh_i[3:0].
- R3: With rs485_en_i=0 and auto_rts_en_i=0, rts_no equals the inverse of manual_rts_i, one cycle later.
- R4: With rs485_en_i=1, rts_no equals the inverse of tx_busy_i one cycle later, whatever the auto and manual inputs are.
- R5: Automatic control takes precedence over manual_rts_i. With auto_rts_en_i=1, manual_rts_i has no effect on rts_no.
- R6: With sw_flow_en_i=1, no request pending and the unit not halted, a level above 4*thresh_i[3:0] raises send_req_o one cycle later, with send_char_o equal to xoff_char_i. The unit is then halted.
- R7: With sw_flow_en_i=1, no request pending and the unit halted, a level at or below 4*thresh_i[7:4] raises send_req_o one cycle later, with send_char_o equal to xon_char_i. The unit is then no longer halted.
- R8: While the level stays above the halt limit after a stop character has been accepted, no further request is raised.
- R9: A raised request keeps send_req_o=1 and send_char_o stable until send_ack_i=1 is seen with it. send_req_o is 0 in the following cycle. send_ack_i has no effect while no request is pending.
- R10: sw_flow_en_i=0 clears any pending request and the halted state one cycle later. No request is raised while it is 0.
- R11: The halt limit is 4*thresh_i[3:0] and the resume limit is 4*thresh_i[7:4]. For example, with thresh_i=8'h28, level 31 gives rts_no=0 and level 32 gives rts_no=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | 7 | Receive FIFO fill level, 0 to 64 |
| thresh_i | input | 8 | [3:0] halt field, [7:4] resume field, each in units of 4 entries |
| auto_rts_en_i | input | 1 | Enable level-driven ready-to-send control |
| sw_flow_en_i | input | 1 | Enable stop/resume character requests |
| manual_rts_i | input | 1 | Manual ready-to-send; 1 drives the pin low |
| rs485_en_i | input | 1 | RS-485 direction override |
| tx_busy_i | input | 1 | Transmitter has data in flight |
| xon_char_i | input | 8 | Resume character value |
| xoff_char_i | input | 8 | Stop character value |
| send_ack_i | input | 1 | Transmitter accepts the pending character |
| rts_no | output | 1 | Ready-to-send pin, active low |
| send_req_o | output | 1 | Character insertion request |
| send_char_o | output | 8 | Character to insert |

## Verification
Every result of this block lands exactly one clock edge after the inputs that cause it. This covers the pin level, a new request, the clearing of a request after an acknowledge, and the clearing after software mode is switched off. The bench sets inputs at the falling edge and computes the expected pin and request state from those inputs and its own copy of the halted and pending state. It compares one time unit after the next rising edge. The directed cases are placed so that the threshold boundaries (one entry below and exactly at a limit), the precedence order, and the once-per-crossing rule are each observed in the cycle right after the stimulus.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    RTS_SRC_MANUAL = 2'd0,
    RTS_SRC_AUTO   = 2'd1,
    RTS_SRC_DIR    = 2'd2
  } rts_src_e;
endpackage

// File: rtl/rfc_thresh.sv
module rfc_thresh #(
  parameter int LVL_W   = 7,
  parameter int FIELD_W = 4,
  parameter int SCALE   = 4
) (
  input  logic [LVL_W-1:0]     level_i,
  input  logic [2*FIELD_W-1:0] thresh_i,
  output logic                 below_halt_o,
  output logic                 above_halt_o,
  output logic                 at_resume_o
);
  localparam int SH = $clog2(SCALE);

  logic [LVL_W-1:0] halt_lvl, resume_lvl;

  generate
    if ((1 << SH) == SCALE) begin : g_shift
      assign halt_lvl   = LVL_W'(thresh_i[FIELD_W-1:0]) << SH;
      assign resume_lvl = LVL_W'(thresh_i[2*FIELD_W-1:FIELD_W]) << SH;
    end else begin : g_mult
      assign halt_lvl   = LVL_W'(thresh_i[FIELD_W-1:0]) * LVL_W'(SCALE);
      assign resume_lvl = LVL_W'(thresh_i[2*FIELD_W-1:FIELD_W]) * LVL_W'(SCALE);
    end
  endgenerate

  assign below_halt_o = level_i <  halt_lvl;
  assign above_halt_o = level_i >  halt_lvl;
  assign at_resume_o  = level_i <= resume_lvl;
endmodule

// File: rtl/rfc_rts_sel.sv
module rfc_rts_sel
  import rfc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_en_i,
  input  logic auto_en_i,
  input  logic tx_busy_i,
  input  logic below_halt_i,
  input  logic manual_i,
  output logic rts_no
);
  rts_src_e src;
  logic     rts_n_d;

  always_comb begin
    if (dir_en_i)       src = RTS_SRC_DIR;
    else if (auto_en_i) src = RTS_SRC_AUTO;
    else                src = RTS_SRC_MANUAL;
  end

  always_comb begin
    unique case (src)
      RTS_SRC_DIR:  rts_n_d = ~tx_busy_i;
      RTS_SRC_AUTO: rts_n_d = ~below_halt_i;
      default:      rts_n_d = ~manual_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_no <= 1'b1;
    else         rts_no <= rts_n_d;
  end
endmodule

// File: rtl/rfc_xchar.sv
module rfc_xchar #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              above_halt_i,
  input  logic              at_resume_i,
  input  logic [CHAR_W-1:0] xon_i,
  input  logic [CHAR_W-1:0] xoff_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [CHAR_W-1:0] char_o
);
  logic halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      req_o    <= 1'b0;
      char_o   <= '0;
    end else if (!en_i) begin
      halted_q <= 1'b0;
      req_o    <= 1'b0;
    end else if (req_o) begin
      // hold until the transmitter takes it
      if (ack_i) req_o <= 1'b0;
    end else if (!halted_q && above_halt_i) begin
      req_o    <= 1'b1;
      char_o   <= xoff_i;
      halted_q <= 1'b1;
    end else if (halted_q && at_resume_i) begin
      req_o    <= 1'b1;
      char_o   <= xon_i;
      halted_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl #(
  parameter int FIFO_DEPTH = 64,
  parameter int FIELD_W    = 4,
  parameter int LVL_SCALE  = 4,
  parameter int CHAR_W     = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LVL_W-1:0]     rx_level_i,
  input  logic [2*FIELD_W-1:0] thresh_i,
  input  logic                 auto_rts_en_i,
  input  logic                 sw_flow_en_i,
  input  logic                 manual_rts_i,
  input  logic                 rs485_en_i,
  input  logic                 tx_busy_i,
  input  logic [CHAR_W-1:0]    xon_char_i,
  input  logic [CHAR_W-1:0]    xoff_char_i,
  input  logic                 send_ack_i,
  output logic                 rts_no,
  output logic                 send_req_o,
  output logic [CHAR_W-1:0]    send_char_o
);
  logic below_halt, above_halt, at_resume;

  rfc_thresh #(
    .LVL_W  (LVL_W),
    .FIELD_W(FIELD_W),
    .SCALE  (LVL_SCALE)
  ) u_thresh (
    .level_i     (rx_level_i),
    .thresh_i    (thresh_i),
    .below_halt_o(below_halt),
    .above_halt_o(above_halt),
    .at_resume_o (at_resume)
  );

  rfc_rts_sel u_rts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_en_i    (rs485_en_i),
    .auto_en_i   (auto_rts_en_i),
    .tx_busy_i   (tx_busy_i),
    .below_halt_i(below_halt),
    .manual_i    (manual_rts_i),
    .rts_no      (rts_no)
  );

  rfc_xchar #(.CHAR_W(CHAR_W)) u_xchar (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (sw_flow_en_i),
    .above_halt_i(above_halt),
    .at_resume_i (at_resume),
    .xon_i       (xon_char_i),
    .xoff_i      (xoff_char_i),
    .ack_i       (send_ack_i),
    .req_o       (send_req_o),
    .char_o      (send_char_o)
  );
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              auto_rts_en_i,
  input logic              sw_flow_en_i,
  input logic              manual_rts_i,
  input logic              rs485_en_i,
  input logic              tx_busy_i,
  input logic              send_ack_i,
  input logic              rts_no,
  input logic              send_req_o,
  input logic [CHAR_W-1:0] send_char_o
);
  p_dir_override_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs485_en_i |=> (rts_no == !$past(tx_busy_i)));

  p_manual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rs485_en_i && !auto_rts_en_i) |=> (rts_no == !$past(manual_rts_i)));

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_req_o && !send_ack_i && sw_flow_en_i) |=> (send_req_o && $stable(send_char_o)));

  p_ack_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_req_o && send_ack_i) |=> !send_req_o);

  p_sw_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_flow_en_i |=> !send_req_o);
endmodule

bind rx_flow_ctrl rfc_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .auto_rts_en_i(auto_rts_en_i),
  .sw_flow_en_i (sw_flow_en_i),
  .manual_rts_i (manual_rts_i),
  .rs485_en_i   (rs485_en_i),
  .tx_busy_i    (tx_busy_i),
  .send_ack_i   (send_ack_i),
  .rts_no       (rts_no),
  .send_req_o   (send_req_o),
  .send_char_o  (send_char_o)
);

// File: tb/rx_flow_ctrl_test.sv
module rx_flow_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] level = '0;
  logic [7:0] thr = '0;
  logic       auto_en = 0, sw_en = 0, man = 0, dir = 0, busy = 0, ack = 0;
  logic [7:0] xon = 8'h11, xoff = 8'h13;
  logic       rts_n, req;
  logic [7:0] ch;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit       m_halt = 0, m_req = 0;
  bit [7:0] m_char = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_flow_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_level_i(level), .thresh_i(thr),
    .auto_rts_en_i(auto_en), .sw_flow_en_i(sw_en), .manual_rts_i(man),
    .rs485_en_i(dir), .tx_busy_i(busy), .xon_char_i(xon), .xoff_char_i(xoff),
    .send_ack_i(ack), .rts_no(rts_n), .send_req_o(req), .send_char_o(ch)
  );

  function automatic bit exp_rts_n();
    if (dir)     return !busy;
    if (auto_en) return !(int'(level) < 4 * int'(thr[3:0]));
    return !man;
  endfunction

  function automatic string rts_tag();
    if (dir)     return "R4";
    if (auto_en) return man ? "R5" : "R2";
    return "R3";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs already applied after a falling edge; step through the next rising edge
  task automatic tick(input string req_tag);
    bit    e_rts;
    string rt;
    e_rts = exp_rts_n();
    rt    = rts_tag();
    if (!sw_en) begin
      m_halt = 0; m_req = 0;
    end else if (m_req) begin
      if (ack) m_req = 0;
    end else if (!m_halt && int'(level) > 4 * int'(thr[3:0])) begin
      m_req = 1; m_char = xoff; m_halt = 1;
    end else if (m_halt && int'(level) <= 4 * int'(thr[7:4])) begin
      m_req = 1; m_char = xon; m_halt = 0;
    end
    @(posedge clk); #1;
    check(rt, int'(rts_n), int'(e_rts));
    check(req_tag, int'(req), int'(m_req));
    if (m_req) check(req_tag, int'(ch), int'(m_char));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(rts_n), 1);
    check("R1", int'(req), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(rts_n), 1);

    // R11 boundary: halt 32, resume 8
    thr = 8'h28; auto_en = 1;
    level = 7'd31; tick("R11");
    check("R11", int'(rts_n), 0);
    level = 7'd32; tick("R11");
    check("R11", int'(rts_n), 1);

    // R5 manual ignored under auto
    man = 1; level = 7'd40; tick("R5");
    check("R5", int'(rts_n), 1);
    // R3 manual alone
    auto_en = 0; tick("R3");
    check("R3", int'(rts_n), 0);
    // R4 override
    dir = 1; busy = 0; tick("R4");
    check("R4", int'(rts_n), 1);
    busy = 1; tick("R4");
    check("R4", int'(rts_n), 0);
    dir = 0; busy = 0; man = 0;

    // R6 stop character, R9 hold, R8 once per crossing
    sw_en = 1; level = 7'd33; tick("R6");
    check("R6", int'(req), 1);
    check("R6", int'(ch), int'(xoff));
    level = 7'd50; tick("R9");
    tick("R9");
    check("R9", int'(req), 1);
    ack = 1; tick("R9");
    check("R9", int'(req), 0);
    ack = 0;
    for (int i = 0; i < 4; i++) tick("R8");
    check("R8", int'(req), 0);
    // R7 resume character at the limit
    level = 7'd9; tick("R7");
    check("R7", int'(req), 0);
    level = 7'd8; tick("R7");
    check("R7", int'(req), 1);
    check("R7", int'(ch), int'(xon));
    ack = 1; tick("R9");
    ack = 0;
    // R10 disable clears pending request
    level = 7'd64; tick("R6");
    check("R6", int'(req), 1);
    sw_en = 0; tick("R10");
    check("R10", int'(req), 0);
    sw_en = 1; tick("R10");
    check("R10", int'(req), 1);
    ack = 1; tick("R9"); ack = 0;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      level   = 7'($urandom_range(0, 64));
      if (($urandom % 16) == 0) thr = 8'($urandom);
      auto_en = ($urandom % 3) != 0;
      sw_en   = ($urandom % 20) != 0;
      man     = 1'($urandom);
      dir     = ($urandom % 5) == 0;
      busy    = 1'($urandom);
      ack     = ($urandom % 3) == 0;
      if (($urandom % 50) == 0) begin
        xon = 8'($urandom); xoff = 8'($urandom);
      end
      tick(ack ? "R9" : "R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule